// File: doc/BRIEF.md
# Threshold-Requesting Serial Word Buffer Pair

This block sits between a host bus and a serial port and holds two word queues: one carries words from the host out to the serializer, the other carries words from the deserializer back to the host. Each queue keeps 16 entries of 32 bits. The host writes the outbound queue and reads the inbound queue through a simple enable/data interface. Every host access moves exactly one whole entry, whatever the access size. The serial side drains the outbound queue and fills the inbound queue one word per cycle.

Each direction raises a transfer request for an interrupt or DMA engine. A 3-bit watermark code sets the level at which the request fires, and the two directions are programmed separately. The outbound request compares the number of free entries against the threshold. The inbound request compares the number of held entries against it. The most permissive code (a threshold of one entry) is illegal when requests go to a DMA engine. If that combination is programmed, the block flags it and holds that request low. A host write to a full outbound queue and a host read from an empty inbound queue are each recorded in a sticky flag.

Top module: `wm_serial_fifo_pair`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge), both counts are 0, tx_overflow and rx_underflow are 0, ser_tx_valid is 0, ser_rx_ready is 1, rx_req is 0, and with code 000 tx_req is 1.
- R2: Each accepted host write adds exactly one 32-bit entry to the outbound queue, so tx_count rises by one. Entries leave on ser_tx_data in the order they were written.
- R3: tx_req is 1 when the number of free outbound entries (16 - tx_count) is at least the threshold selected by tx_wm. The code-to-threshold map is 000→16, 100→12, 101→8, 110→4, 111→1.
- R4: rx_req is 1 when rx_count is at least the threshold selected by rx_wm, using the same code-to-threshold map as R3.
- R5: Codes 001, 010 and 011 select the same threshold as 000, which is 16 entries.
- R6: When dma_mode is 1 and a direction's code is 111, wm_err is 1 and that direction's request is 0. With dma_mode 0, code 111 works normally and wm_err is 0.
- R7: A host write while tx_count is 16 is discarded. The count stays 16, no stored word changes, and tx_overflow becomes 1 and stays 1 until reset.
- R8: A host read while rx_count is 0 returns 0 on host_rd_data, leaves the count at 0, and sets rx_underflow, which stays 1 until reset.
- R9: The requests are combinational in the counts and codes. They reflect a push or pop in the same cycle that the count changes, and they follow a code change with no clock edge.
- R10: When a push and a pop reach the same queue in one cycle and both are legal, both take effect and the count does not change. On a full outbound queue, the pop proceeds and the write is discarded as in R7.
- R11: ser_tx_valid is 1 exactly when the outbound queue is not empty, and a serial pop while it is empty is ignored. ser_rx_ready is 1 exactly when the inbound queue is not full, and a serial push while it is full is dropped without setting any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dma_mode | input | 1 | Requests are serviced by a DMA engine |
| tx_wm | input | 3 | Outbound watermark code |
| rx_wm | input | 3 | Inbound watermark code |
| host_wr_en | input | 1 | Host writes one entry into the outbound queue |
| host_wr_data | input | 32 | Host write word |
| host_rd_en | input | 1 | Host reads one entry from the inbound queue |
| host_rd_data | output | 32 | Head of the inbound queue, 0 when empty |
| ser_tx_pop | input | 1 | Serializer takes the outbound head |
| ser_tx_valid | output | 1 | Outbound queue not empty |
| ser_tx_data | output | 32 | Outbound head word, 0 when empty |
| ser_rx_push | input | 1 | Deserializer delivers a word |
| ser_rx_data | input | 32 | Delivered word |
| ser_rx_ready | output | 1 | Inbound queue not full |
| tx_count | output | 5 | Entries held in the outbound queue |
| rx_count | output | 5 | Entries held in the inbound queue |
| tx_req | output | 1 | Outbound transfer request |
| rx_req | output | 1 | Inbound transfer request |
| wm_err | output | 1 | Illegal code programmed while in DMA mode |
| tx_overflow | output | 1 | Sticky: write to a full outbound queue |
| rx_underflow | output | 1 | Sticky: read from an empty inbound queue |

## Verification
A host access and a serial-side access can reach the same queue in the same cycle. The bench provokes this in three ways. A host write and a serial pop hit a partly filled outbound queue, and the count must hold while the head advances. The same pair then hits a full outbound queue, where the pop must drain an entry and the write must be lost with tx_overflow set. Finally, a host read and a serial push reach an empty inbound queue together: the read must return zero and set rx_underflow, and the pushed word must still land and be read back afterwards.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int WORD_W    = 32;
    localparam int FIFO_SIZE = 16;
    localparam int WM_W      = 3;

    typedef logic [WM_W-1:0] wm_code_t;

    localparam wm_code_t WM_ONE_ENTRY = 3'b111;

endpackage

// File: rtl/wm_fifo.sv
module wm_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t state_d, state_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full  = (state_q.cnt == CNT_W'(DEPTH));
    assign empty = (state_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign count = state_q.cnt;
    assign head_data = mem_q[state_q.rd];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        state_d = state_q;
        if (push_ok) state_d.wr = bump(state_q.wr);
        if (pop_ok)  state_d.rd = bump(state_q.rd);
        case ({push_ok, pop_ok})
            2'b10:   state_d.cnt = state_q.cnt + 1'b1;
            2'b01:   state_d.cnt = state_q.cnt - 1'b1;
            default: state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[state_q.wr] <= push_data;
    end

    // R2: occupancy never exceeds the entry count
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R2: a lone accepted push grows the count by exactly one entry
    assert_push_one_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (count == $past(count) + 1'b1));

    // R10: legal push and pop together leave the count unchanged
    assert_push_pop_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !full && !empty) |=> $stable(count));

    // R11: a pop of an empty queue changes nothing
    assert_empty_pop_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/wm_thresh.sv
module wm_thresh
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter bit COUNT_FREE = 1'b1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dma_mode,
    input  wm_code_t         code,
    input  logic [CNT_W-1:0] count,
    output logic             req,
    output logic             bad_code
);

    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] thr;

    generate
        if (COUNT_FREE) begin : g_free
            assign level = CNT_W'(DEPTH) - count;
        end else begin : g_held
            assign level = count;
        end
    endgenerate

    always_comb begin
        case (code)
            3'b100:  thr = CNT_W'(DEPTH - DEPTH / 4);
            3'b101:  thr = CNT_W'(DEPTH / 2);
            3'b110:  thr = CNT_W'(DEPTH / 4);
            3'b111:  thr = CNT_W'(1);
            default: thr = CNT_W'(DEPTH);
        endcase
    end

    assign bad_code = dma_mode && (code == WM_ONE_ENTRY);
    assign req = !bad_code && (level >= thr);

    // R6: the forbidden combination never produces a request
    assert_dma_forbid_R6: assert property (@(posedge clk) disable iff (rst)
        (dma_mode && code == 3'b111) |-> !req);

    // R5: the low codes all demand a completely free or completely held queue
    assert_low_codes_R5: assert property (@(posedge clk) disable iff (rst)
        (code[2] == 1'b0 && req) |-> (level == CNT_W'(DEPTH)));

endmodule

// File: rtl/wm_serial_fifo_pair.sv
module wm_serial_fifo_pair
    import sfifo_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int DEPTH = FIFO_SIZE,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dma_mode,
    input  logic [2:0]       tx_wm,
    input  logic [2:0]       rx_wm,
    input  logic             host_wr_en,
    input  logic [WIDTH-1:0] host_wr_data,
    input  logic             host_rd_en,
    output logic [WIDTH-1:0] host_rd_data,
    input  logic             ser_tx_pop,
    output logic             ser_tx_valid,
    output logic [WIDTH-1:0] ser_tx_data,
    input  logic             ser_rx_push,
    input  logic [WIDTH-1:0] ser_rx_data,
    output logic             ser_rx_ready,
    output logic [CNT_W-1:0] tx_count,
    output logic [CNT_W-1:0] rx_count,
    output logic             tx_req,
    output logic             rx_req,
    output logic             wm_err,
    output logic             tx_overflow,
    output logic             rx_underflow
);

    typedef struct packed {
        logic tx_ovf;
        logic rx_unf;
    } flags_t;

    flags_t flags_d, flags_q;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_bad, rx_bad;
    logic [WIDTH-1:0] tx_head, rx_head;

    wm_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (host_wr_en),
        .push_data (host_wr_data),
        .pop       (ser_tx_pop),
        .head_data (tx_head),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    wm_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (ser_rx_push),
        .push_data (ser_rx_data),
        .pop       (host_rd_en),
        .head_data (rx_head),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    wm_thresh #(.DEPTH(DEPTH), .COUNT_FREE(1'b1)) u_tx_thresh (
        .clk      (clk),
        .rst      (rst),
        .dma_mode (dma_mode),
        .code     (tx_wm),
        .count    (tx_count),
        .req      (tx_req),
        .bad_code (tx_bad)
    );

    wm_thresh #(.DEPTH(DEPTH), .COUNT_FREE(1'b0)) u_rx_thresh (
        .clk      (clk),
        .rst      (rst),
        .dma_mode (dma_mode),
        .code     (rx_wm),
        .count    (rx_count),
        .req      (rx_req),
        .bad_code (rx_bad)
    );

    assign wm_err       = tx_bad || rx_bad;
    assign ser_tx_valid = !tx_empty;
    assign ser_rx_ready = !rx_full;
    assign ser_tx_data  = tx_empty ? '0 : tx_head;
    assign host_rd_data = rx_empty ? '0 : rx_head;

    always_comb begin
        flags_d = flags_q;
        if (host_wr_en && tx_full)  flags_d.tx_ovf = 1'b1;
        if (host_rd_en && rx_empty) flags_d.rx_unf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign tx_overflow  = flags_q.tx_ovf;
    assign rx_underflow = flags_q.rx_unf;

    // R7: overflow flag is sticky
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        tx_overflow |=> tx_overflow);

    // R7: a write into a full queue with no drain keeps it full
    assert_full_write_dropped_R7: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && tx_count == CNT_W'(DEPTH) && !ser_tx_pop) |=> (tx_count == CNT_W'(DEPTH) && tx_overflow));

    // R8: underflow flag is sticky
    assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        rx_underflow |=> rx_underflow);

    // R8: reading an empty inbound queue yields zero
    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && rx_count == '0) |-> (host_rd_data == '0));

    // R11: a full inbound queue refuses further words without flagging
    assert_rx_full_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (ser_rx_push && !ser_rx_ready && !host_rd_en) |=> (rx_count == CNT_W'(DEPTH) && $stable(rx_underflow)));

endmodule

// File: tb/wm_serial_fifo_pair_tb.sv
module wm_serial_fifo_pair_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dma_mode = 1'b0;
    logic [2:0]  tx_wm = 3'b000;
    logic [2:0]  rx_wm = 3'b000;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [31:0] host_rd_data;
    logic        ser_tx_pop = 1'b0;
    logic        ser_tx_valid;
    logic [31:0] ser_tx_data;
    logic        ser_rx_push = 1'b0;
    logic [31:0] ser_rx_data = '0;
    logic        ser_rx_ready;
    logic [4:0]  tx_count, rx_count;
    logic        tx_req, rx_req, wm_err, tx_overflow, rx_underflow;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wm_serial_fifo_pair u_dut (
        .clk(clk), .rst(rst), .dma_mode(dma_mode), .tx_wm(tx_wm), .rx_wm(rx_wm),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .ser_tx_pop(ser_tx_pop), .ser_tx_valid(ser_tx_valid), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .ser_rx_ready(ser_rx_ready),
        .tx_count(tx_count), .rx_count(rx_count), .tx_req(tx_req), .rx_req(rx_req),
        .wm_err(wm_err), .tx_overflow(tx_overflow), .rx_underflow(rx_underflow)
    );

    // {code, fill level, expected tx_req, expected rx_req}; both codes equal
    localparam logic [9:0] VEC [NVEC] = '{
        {3'b000, 5'd0,  1'b1, 1'b0},
        {3'b000, 5'd1,  1'b0, 1'b0},
        {3'b000, 5'd16, 1'b0, 1'b1},
        {3'b010, 5'd0,  1'b1, 1'b0},
        {3'b011, 5'd15, 1'b0, 1'b0},
        {3'b100, 5'd4,  1'b1, 1'b0},
        {3'b100, 5'd5,  1'b0, 1'b0},
        {3'b101, 5'd8,  1'b1, 1'b1},
        {3'b101, 5'd9,  1'b0, 1'b1},
        {3'b101, 5'd7,  1'b1, 1'b0},
        {3'b110, 5'd12, 1'b1, 1'b1},
        {3'b110, 5'd13, 1'b0, 1'b1},
        {3'b110, 5'd3,  1'b1, 1'b0},
        {3'b111, 5'd15, 1'b1, 1'b1},
        {3'b111, 5'd16, 1'b0, 1'b1},
        {3'b111, 5'd0,  1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic do_reset();
        rst = 1'b1;
        host_wr_en = 0; host_rd_en = 0; ser_tx_pop = 0; ser_rx_push = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic host_write(input logic [31:0] d);
        host_wr_en = 1'b1; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic ser_push(input logic [31:0] d);
        ser_rx_push = 1'b1; ser_rx_data = d;
        @(negedge clk);
        ser_rx_push = 1'b0;
    endtask

    task automatic host_read(output logic [31:0] d);
        host_rd_en = 1'b1;
        #1 d = host_rd_data;
        @(negedge clk);
        host_rd_en = 1'b0;
    endtask

    task automatic ser_pop();
        ser_tx_pop = 1'b1;
        @(negedge clk);
        ser_tx_pop = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 tx_count", 32'(tx_count), 0);
        chk("R1 rx_count", 32'(rx_count), 0);
        chk("R1 tx_overflow", 32'(tx_overflow), 0);
        chk("R1 rx_underflow", 32'(rx_underflow), 0);
        chk("R1 ser_tx_valid", 32'(ser_tx_valid), 0);
        chk("R1 ser_rx_ready", 32'(ser_rx_ready), 1);
        chk("R1 tx_req", 32'(tx_req), 1);
        chk("R1 rx_req", 32'(rx_req), 0);

        // R3 R4 R5 threshold table
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            tx_wm = VEC[v][9:7];
            rx_wm = VEC[v][9:7];
            for (int k = 0; k < int'(VEC[v][6:2]); k++) begin
                host_wr_en = 1'b1; host_wr_data = 32'(k);
                ser_rx_push = 1'b1; ser_rx_data = 32'(k);
                @(negedge clk);
            end
            host_wr_en = 1'b0; ser_rx_push = 1'b0;
            chk("R3 tx_req vector", 32'(tx_req), 32'(VEC[v][1]));
            chk("R4 rx_req vector", 32'(rx_req), 32'(VEC[v][0]));
        end

        // R2 R11 ordering, one entry per access
        do_reset();
        tx_wm = 3'b000; rx_wm = 3'b000;
        host_write(32'hA0A0_0001);
        chk("R9 tx_req drops with first entry", 32'(tx_req), 0);
        host_write(32'hA0A0_0002);
        host_write(32'hA0A0_0003);
        chk("R2 tx_count after 3 writes", 32'(tx_count), 3);
        chk("R11 ser_tx_valid", 32'(ser_tx_valid), 1);
        chk("R2 head first", ser_tx_data, 32'hA0A0_0001);
        ser_pop();
        chk("R2 head second", ser_tx_data, 32'hA0A0_0002);
        // R10 write and pop together
        host_wr_en = 1'b1; host_wr_data = 32'hA0A0_0004; ser_tx_pop = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0; ser_tx_pop = 1'b0;
        chk("R10 tx_count hold", 32'(tx_count), 2);
        chk("R10 head after concurrent", ser_tx_data, 32'hA0A0_0003);
        ser_pop(); ser_pop();
        chk("R2 drain empty", 32'(tx_count), 0);
        ser_pop();
        chk("R11 empty pop ignored", 32'(tx_count), 0);
        chk("R11 valid low", 32'(ser_tx_valid), 0);
        chk("R9 tx_req back", 32'(tx_req), 1);

        // R9 code change is seen without a clock edge
        host_write(32'h5);
        tx_wm = 3'b111; #1;
        chk("R9 code change immediate", 32'(tx_req), 1);
        tx_wm = 3'b000; #1;
        chk("R9 code change back", 32'(tx_req), 0);
        @(negedge clk);

        // R7 overflow and R10 on full
        do_reset();
        for (int k = 0; k < 16; k++) host_write(32'hB000_0000 + 32'(k));
        chk("R7 full count", 32'(tx_count), 16);
        host_write(32'hDEAD_BEEF);
        chk("R7 count stays", 32'(tx_count), 16);
        chk("R7 overflow set", 32'(tx_overflow), 1);
        host_wr_en = 1'b1; host_wr_data = 32'hDEAD_0001; ser_tx_pop = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0; ser_tx_pop = 1'b0;
        chk("R10 full write dropped pop kept", 32'(tx_count), 15);
        for (int k = 1; k < 16; k++) begin
            chk("R7 stored word intact", ser_tx_data, 32'hB000_0000 + 32'(k));
            ser_pop();
        end
        chk("R7 overflow sticky", 32'(tx_overflow), 1);
        chk("R7 empty after drain", 32'(ser_tx_valid), 0);

        // R8 underflow, R10 read and push together on empty
        do_reset();
        ser_rx_push = 1'b1; ser_rx_data = 32'hC0DE_0001; host_rd_en = 1'b1;
        #1 rd = host_rd_data;
        @(negedge clk);
        ser_rx_push = 1'b0; host_rd_en = 1'b0;
        chk("R8 empty read zero", rd, 0);
        chk("R8 underflow set", 32'(rx_underflow), 1);
        chk("R10 push landed", 32'(rx_count), 1);
        host_read(rd);
        chk("R2 rx word", rd, 32'hC0DE_0001);
        host_read(rd);
        chk("R8 second empty read zero", rd, 0);
        chk("R8 count stays zero", 32'(rx_count), 0);
        chk("R8 underflow sticky", 32'(rx_underflow), 1);

        // R11 inbound full drop
        do_reset();
        for (int k = 0; k < 16; k++) ser_push(32'hE000_0000 + 32'(k));
        chk("R11 ready low when full", 32'(ser_rx_ready), 0);
        ser_push(32'hFFFF_FFFF);
        chk("R11 full push dropped", 32'(rx_count), 16);
        chk("R11 no flag", 32'(rx_underflow), 0);
        for (int k = 0; k < 16; k++) begin
            host_read(rd);
            chk("R11 rx order", rd, 32'hE000_0000 + 32'(k));
        end

        // R6 DMA restriction
        do_reset();
        dma_mode = 1'b1; tx_wm = 3'b111; rx_wm = 3'b000; #1;
        chk("R6 wm_err tx", 32'(wm_err), 1);
        chk("R6 tx_req suppressed", 32'(tx_req), 0);
        dma_mode = 1'b0; #1;
        chk("R6 no err without dma", 32'(wm_err), 0);
        chk("R6 tx_req without dma", 32'(tx_req), 1);
        ser_push(32'h1);
        dma_mode = 1'b1; tx_wm = 3'b000; rx_wm = 3'b111; #1;
        chk("R6 wm_err rx", 32'(wm_err), 1);
        chk("R6 rx_req suppressed", 32'(rx_req), 0);
        chk("R6 tx_req unaffected", 32'(tx_req), 1);
        dma_mode = 1'b0; #1;
        chk("R6 rx_req without dma", 32'(rx_req), 1);
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule